// File: doc/BRIEF.md
# Reset and Wake Cause Register

This block holds an 8-bit status register that records why the core last restarted or woke up. Single-cycle event strobes arrive from detection logic outside the block: power-on, brown-out, a software reset instruction, an external reset pin, a watchdog time-out, a stack-full condition, a stack-underflow condition and an interrupt wake-up. Each strobe changes only the flags that belong to it. The rest of the register keeps its value, so after a restart firmware can tell the causes apart, including the sticky active-low power-on and brown-out flags.

Alongside the register, the block keeps two sticky stack-error flags. It also reports where execution resumes: the reset vector, the next instruction, or one of two interrupt vectors. The choice depends on the event, on whether the core was running, idle or asleep, and on the two global interrupt enables. Software can write the writable register bits. This is how it re-arms the power-on and brown-out flags.

Top module: `rst_cause_reg`

## Requirements
- R1: Bits 6 and 5 of `cause_q` always read 0. While `rst_n` is low at a clock edge, the block loads `cause_q` = 0x1C, clears both stack flags and holds `restart_valid` low.
- R2: A power-on strobe loads `cause_q` = 0x1C (bit 7 priority enable 0, bit 4 reset-instruction 1, bit 3 time-out 1, bit 2 power-down 1, bit 1 power-on 0, bit 0 brown-out 0) and clears both stack flags. It restarts at the reset vector. It overrides every other strobe and any write in the same cycle.
- R3: A software reset strobe clears bit 4 only and restarts at the reset vector.
- R4: A brown-out strobe sets bits 4, 3 and 2 and clears bit 0. It leaves bits 7 and 1 and the stack flags unchanged and restarts at the reset vector. It overrides every strobe except power-on.
- R5: A pin reset sets bit 3. When `core_mode` is not 0 (0 = running, 1 = idle, 2 or 3 = asleep), it also clears bit 2. It restarts at the reset vector.
- R6: A watchdog time-out clears bit 3. When running, it restarts at the reset vector (`restart_sel` = 0). When idle or asleep, it also clears bit 2 and resumes at the next instruction (`restart_sel` = 1).
- R7: A stack-full strobe with `stack_rst_en` = 1 sets `stack_full_q` and restarts at the reset vector. With `stack_rst_en` = 0, the strobe has no effect.
- R8: A stack-underflow strobe always sets `stack_under_q`. It restarts at the reset vector only when `stack_rst_en` = 1. Otherwise `restart_valid` stays low.
- R9: An interrupt wake while idle or asleep clears bit 2. It resumes at `restart_sel` = 2 (vector 0x08) if `gie_high`, else at 3 (vector 0x18) if `gie_low`, else at 1 (next instruction). While running, the strobe has no effect.
- R10: With no effective strobe, a software write loads bits 7, 4, 1 and 0 from `sw_wr_data` and leaves bits 3, 2, 6 and 5 unchanged. A write in the same cycle as an effective strobe is dropped.
- R11: Among the remaining strobes, only the highest-priority effective one acts. The order is pin reset, watchdog, software reset, stack-full, stack-underflow, interrupt wake.
- R12: `restart_valid` pulses for exactly the one cycle after an event that restarts the core. `restart_sel` reads 0 whenever `restart_valid` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ev_power_on | input | 1 | Power-on event strobe |
| ev_brownout | input | 1 | Brown-out event strobe |
| ev_soft_reset | input | 1 | Software reset instruction strobe |
| ev_pin_reset | input | 1 | External reset pin strobe |
| ev_watchdog | input | 1 | Watchdog time-out strobe |
| ev_stack_full | input | 1 | Stack-full strobe |
| ev_stack_under | input | 1 | Stack-underflow strobe |
| ev_int_wake | input | 1 | Interrupt wake strobe |
| core_mode | input | 2 | 0 running, 1 idle, 2/3 asleep |
| stack_rst_en | input | 1 | Stack errors cause a restart |
| gie_high | input | 1 | High-priority global interrupt enable |
| gie_low | input | 1 | Low-priority global interrupt enable |
| sw_wr_en | input | 1 | Software write strobe |
| sw_wr_data | input | 8 | Software write data |
| cause_q | output | 8 | Cause register |
| stack_full_q | output | 1 | Sticky stack-full flag |
| stack_under_q | output | 1 | Sticky stack-underflow flag |
| restart_valid | output | 1 | Restart target is valid this cycle |
| restart_sel | output | 2 | 0 reset vector, 1 next instruction, 2 vector 0x08, 3 vector 0x18 |

## Verification
The hardest situations to reach are the collisions: several strobes, or a strobe and a software write, landing in one cycle, where only one source may act. These must also be combined with the core mode and the two interrupt enables, which change the outcome of the same strobe. Directed steps first drive each source alone in each mode. They then stack strobes in pairs and triples against a write. A long random phase then fires sparse, overlapping strobes with random modes, enables and write data. A behavioural model of the register is compared on every cycle.

// File: rtl/rcause_pkg.sv
// Package: shared types and constants for the reset cause register.
// Assumes an 8-bit register with fixed flag positions that firmware decodes.
package rcause_pkg;
    localparam int REG_W   = 8;
    localparam int NUM_SRC = 8;
    localparam int SRC_W   = $clog2(NUM_SRC + 1);

    localparam int B_IPEN = 7;
    localparam int B_RI   = 4;
    localparam int B_TO   = 3;
    localparam int B_PD   = 2;
    localparam int B_POR  = 1;
    localparam int B_BOR  = 0;

    localparam logic [REG_W-1:0] POR_VALUE = 8'h1C;
    localparam logic [REG_W-1:0] WR_MASK   = 8'h93;
    localparam logic [REG_W-1:0] IMPL_MASK = 8'h9F;

    // Source codes; the order from SRC_POR upward is the priority order.
    typedef enum logic [SRC_W-1:0] {
        SRC_NONE     = 4'd0,
        SRC_POR      = 4'd1,
        SRC_BOR      = 4'd2,
        SRC_PIN      = 4'd3,
        SRC_WDT      = 4'd4,
        SRC_SWRST    = 4'd5,
        SRC_STKFULL  = 4'd6,
        SRC_STKUNDER = 4'd7,
        SRC_INTWAKE  = 4'd8
    } src_e;

    typedef enum logic [1:0] {
        RS_RESET_VEC = 2'd0,
        RS_NEXT_INSN = 2'd1,
        RS_VEC_HIGH  = 2'd2,
        RS_VEC_LOW   = 2'd3
    } restart_e;
endpackage

// File: rtl/rcause_arbiter.sv
// Module: fixed-priority selection of one event source.
// Assumes the requests are already qualified; bit 0 has the highest priority.
module rcause_arbiter
    import rcause_pkg::*;
#(
    parameter int N = NUM_SRC
) (
    input  logic [N-1:0] req,
    output src_e         winner
);
    // Scan from lowest to highest priority so the last hit wins.
    always_comb begin
        winner = SRC_NONE;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) winner = src_e'(SRC_W'(i + 1));
        end
    end
endmodule

// File: rtl/rcause_flags.sv
// Module: cause register and sticky stack flags.
// Assumes one winning source per cycle; software writes apply only when none wins.
module rcause_flags
    import rcause_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  src_e             winner,
    input  logic             low_power,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    output logic [REG_W-1:0] flags_q,
    output logic             stk_full_q,
    output logic             stk_under_q
);
    logic [REG_W-1:0] flags_d;
    logic             stk_full_d;
    logic             stk_under_d;

    // Next-state for the flag bits from the winning source or a write.
    always_comb begin
        flags_d     = flags_q;
        stk_full_d  = stk_full_q;
        stk_under_d = stk_under_q;
        unique case (winner)
            SRC_POR: begin
                flags_d     = POR_VALUE;
                stk_full_d  = 1'b0;
                stk_under_d = 1'b0;
            end
            SRC_BOR: begin
                flags_d[B_RI]  = 1'b1;
                flags_d[B_TO]  = 1'b1;
                flags_d[B_PD]  = 1'b1;
                flags_d[B_BOR] = 1'b0;
            end
            SRC_PIN: begin
                flags_d[B_TO] = 1'b1;
                if (low_power) flags_d[B_PD] = 1'b0;
            end
            SRC_WDT: begin
                flags_d[B_TO] = 1'b0;
                if (low_power) flags_d[B_PD] = 1'b0;
            end
            SRC_SWRST:    flags_d[B_RI] = 1'b0;
            SRC_STKFULL:  stk_full_d    = 1'b1;
            SRC_STKUNDER: stk_under_d   = 1'b1;
            SRC_INTWAKE:  flags_d[B_PD] = 1'b0;
            default: begin
                if (wr_en) flags_d = (flags_q & ~WR_MASK) | (wr_data & WR_MASK);
            end
        endcase
        flags_d = flags_d & IMPL_MASK;
    end

    // State register with synchronous reset to the power-on image.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags_q     <= POR_VALUE;
            stk_full_q  <= 1'b0;
            stk_under_q <= 1'b0;
        end else begin
            flags_q     <= flags_d;
            stk_full_q  <= stk_full_d;
            stk_under_q <= stk_under_d;
        end
    end

    p_unimpl_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        flags_q[6:5] == 2'b00);

    p_por_image_r2: assert property (@(posedge clk) disable iff (!rst_n)
        winner == SRC_POR |=> flags_q == POR_VALUE && !stk_full_q && !stk_under_q);

    p_swrst_only_ri_r3: assert property (@(posedge clk) disable iff (!rst_n)
        winner == SRC_SWRST |=> flags_q == ($past(flags_q) & ~(8'h01 << B_RI)));

    p_bor_keeps_por_r4: assert property (@(posedge clk) disable iff (!rst_n)
        winner == SRC_BOR |=> flags_q[B_POR] == $past(flags_q[B_POR]) && !flags_q[B_BOR]
                              && $stable(stk_full_q) && $stable(stk_under_q));

    p_wr_masked_r10: assert property (@(posedge clk) disable iff (!rst_n)
        winner == SRC_NONE && wr_en |=> (flags_q & ~WR_MASK) == ($past(flags_q) & ~WR_MASK));

    p_stack_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        stk_full_q && winner != SRC_POR |=> stk_full_q);
endmodule

// File: rtl/rcause_restart.sv
// Module: registered restart target for the winning source.
// Assumes mode and interrupt enables are valid in the cycle of the strobe.
module rcause_restart
    import rcause_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  src_e     winner,
    input  logic     low_power,
    input  logic     stk_rst_en,
    input  logic     gie_high,
    input  logic     gie_low,
    output logic     restart_valid,
    output restart_e restart_sel
);
    logic     valid_d;
    restart_e sel_d;

    // Pick where execution resumes, if the event restarts the core at all.
    always_comb begin
        valid_d = 1'b1;
        sel_d   = RS_RESET_VEC;
        unique case (winner)
            SRC_NONE:     valid_d = 1'b0;
            SRC_WDT:      if (low_power) sel_d = RS_NEXT_INSN;
            SRC_STKUNDER: valid_d = stk_rst_en;
            SRC_INTWAKE: begin
                if (gie_high)     sel_d = RS_VEC_HIGH;
                else if (gie_low) sel_d = RS_VEC_LOW;
                else              sel_d = RS_NEXT_INSN;
            end
            default: sel_d = RS_RESET_VEC;
        endcase
    end

    // Output register; the target reads as reset vector when idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            restart_valid <= 1'b0;
            restart_sel   <= RS_RESET_VEC;
        end else begin
            restart_valid <= valid_d;
            restart_sel   <= valid_d ? sel_d : RS_RESET_VEC;
        end
    end

    p_wdt_lp_next_r6: assert property (@(posedge clk) disable iff (!rst_n)
        winner == SRC_WDT && low_power |=> restart_valid && restart_sel == RS_NEXT_INSN);

    p_under_no_reset_r8: assert property (@(posedge clk) disable iff (!rst_n)
        winner == SRC_STKUNDER && !stk_rst_en |=> !restart_valid);

    p_sel_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !restart_valid |-> restart_sel == RS_RESET_VEC);

    p_wake_high_r9: assert property (@(posedge clk) disable iff (!rst_n)
        winner == SRC_INTWAKE && gie_high |=> restart_sel == RS_VEC_HIGH);
endmodule

// File: rtl/rst_cause_reg.sv
// Module: top of the reset and wake cause register.
// Assumes single-cycle event strobes synchronous to clk; qualifies them and
// hands the single winner to the flag and restart logic.
module rst_cause_reg
    import rcause_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ev_power_on,
    input  logic             ev_brownout,
    input  logic             ev_soft_reset,
    input  logic             ev_pin_reset,
    input  logic             ev_watchdog,
    input  logic             ev_stack_full,
    input  logic             ev_stack_under,
    input  logic             ev_int_wake,
    input  logic [1:0]       core_mode,
    input  logic             stack_rst_en,
    input  logic             gie_high,
    input  logic             gie_low,
    input  logic             sw_wr_en,
    input  logic [REG_W-1:0] sw_wr_data,
    output logic [REG_W-1:0] cause_q,
    output logic             stack_full_q,
    output logic             stack_under_q,
    output logic             restart_valid,
    output logic [1:0]       restart_sel
);
    logic             low_power;
    logic [NUM_SRC-1:0] req;
    src_e             winner;
    restart_e         sel_q;

    // Qualify strobes; index order is the priority order.
    always_comb begin
        low_power = (core_mode != 2'd0);
        req[0] = ev_power_on;
        req[1] = ev_brownout;
        req[2] = ev_pin_reset;
        req[3] = ev_watchdog;
        req[4] = ev_soft_reset;
        req[5] = ev_stack_full & stack_rst_en;
        req[6] = ev_stack_under;
        req[7] = ev_int_wake & low_power;
    end

    rcause_arbiter #(.N(NUM_SRC)) u_arb (
        .req    (req),
        .winner (winner)
    );

    rcause_flags u_flags (
        .clk         (clk),
        .rst_n       (rst_n),
        .winner      (winner),
        .low_power   (low_power),
        .wr_en       (sw_wr_en),
        .wr_data     (sw_wr_data),
        .flags_q     (cause_q),
        .stk_full_q  (stack_full_q),
        .stk_under_q (stack_under_q)
    );

    rcause_restart u_rst (
        .clk           (clk),
        .rst_n         (rst_n),
        .winner        (winner),
        .low_power     (low_power),
        .stk_rst_en    (stack_rst_en),
        .gie_high      (gie_high),
        .gie_low       (gie_low),
        .restart_valid (restart_valid),
        .restart_sel   (sel_q)
    );

    assign restart_sel = sel_q;

    p_por_wins_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ev_power_on |=> cause_q == POR_VALUE);

    p_run_wake_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ev_int_wake && core_mode == 2'd0 && req[6:0] == '0 && !sw_wr_en
        |=> $stable(cause_q) && !restart_valid);

    p_pulse_once_r12: assert property (@(posedge clk) disable iff (!rst_n)
        winner == SRC_NONE |=> !restart_valid);

    p_stkfull_gated_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ev_stack_full && !stack_rst_en && req == '0 |=> $stable(stack_full_q));
endmodule

// File: tb/rst_cause_reg_bench.sv
module rst_cause_reg_bench;
    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic       rst_n;
    logic       ev_power_on, ev_brownout, ev_soft_reset, ev_pin_reset;
    logic       ev_watchdog, ev_stack_full, ev_stack_under, ev_int_wake;
    logic [1:0] core_mode;
    logic       stack_rst_en, gie_high, gie_low, sw_wr_en;
    logic [7:0] sw_wr_data;
    logic [7:0] cause_q;
    logic       stack_full_q, stack_under_q, restart_valid;
    logic [1:0] restart_sel;

    rst_cause_reg u_rst_cause_reg (
        .clk(clk), .rst_n(rst_n),
        .ev_power_on(ev_power_on), .ev_brownout(ev_brownout),
        .ev_soft_reset(ev_soft_reset), .ev_pin_reset(ev_pin_reset),
        .ev_watchdog(ev_watchdog), .ev_stack_full(ev_stack_full),
        .ev_stack_under(ev_stack_under), .ev_int_wake(ev_int_wake),
        .core_mode(core_mode), .stack_rst_en(stack_rst_en),
        .gie_high(gie_high), .gie_low(gie_low),
        .sw_wr_en(sw_wr_en), .sw_wr_data(sw_wr_data),
        .cause_q(cause_q), .stack_full_q(stack_full_q),
        .stack_under_q(stack_under_q), .restart_valid(restart_valid),
        .restart_sel(restart_sel)
    );

    int checks = 0;
    int fails  = 0;
    int m_reg  = 8'h1C;
    bit m_sf = 0, m_su = 0, m_v = 0;
    int m_sel = 0;

    task automatic clear_events();
        ev_power_on = 0; ev_brownout = 0; ev_soft_reset = 0; ev_pin_reset = 0;
        ev_watchdog = 0; ev_stack_full = 0; ev_stack_under = 0; ev_int_wake = 0;
        sw_wr_en = 0; sw_wr_data = 8'h00;
    endtask

    // Behavioural model of one clock edge from the current inputs.
    task automatic model_edge();
        bit lp = (core_mode != 0);
        int r = m_reg;
        bit v = 0;
        int s = 0;
        if (!rst_n) begin
            r = 'h1C; m_sf = 0; m_su = 0;
        end else if (ev_power_on) begin
            r = 'h1C; m_sf = 0; m_su = 0; v = 1;
        end else if (ev_brownout) begin
            r = (r | 'h1C) & ~'h01; v = 1;
        end else if (ev_pin_reset) begin
            r = r | 'h08; if (lp) r = r & ~'h04; v = 1;
        end else if (ev_watchdog) begin
            r = r & ~'h08; if (lp) begin r = r & ~'h04; s = 1; end v = 1;
        end else if (ev_soft_reset) begin
            r = r & ~'h10; v = 1;
        end else if (ev_stack_full && stack_rst_en) begin
            m_sf = 1; v = 1;
        end else if (ev_stack_under) begin
            m_su = 1; v = stack_rst_en;
        end else if (ev_int_wake && lp) begin
            r = r & ~'h04; v = 1;
            s = gie_high ? 2 : (gie_low ? 3 : 1);
        end else if (sw_wr_en) begin
            r = (r & ~'h93) | (sw_wr_data & 'h93);
        end
        m_reg = r & 'h9F;
        m_v = v;
        m_sel = v ? s : 0;
    endtask

    task automatic cycle(string tag);
        logic [12:0] act, exp;
        model_edge();
        @(posedge clk);
        @(negedge clk);
        clear_events();
        act = {cause_q, stack_full_q, stack_under_q, restart_valid, restart_sel};
        exp = {m_reg[7:0], m_sf, m_su, m_v, m_sel[1:0]};
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual reg=%h sf=%b su=%b v=%b sel=%0d expected reg=%h sf=%b su=%b v=%b sel=%0d",
                     tag, act[12:5], act[4], act[3], act[2], act[1:0],
                     exp[12:5], exp[4], exp[3], exp[2], exp[1:0]);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        rst_n = 0; core_mode = 0; stack_rst_en = 1; gie_high = 0; gie_low = 0;
        clear_events();
        @(negedge clk);
        cycle("R1"); cycle("R1");
        rst_n = 1;
        cycle("R1");
        // R10: write all ones; bits 6:5 and 3:2 untouched
        sw_wr_en = 1; sw_wr_data = 8'hFF; cycle("R10");
        sw_wr_en = 1; sw_wr_data = 8'h00; cycle("R10");
        sw_wr_en = 1; sw_wr_data = 8'hFF; cycle("R10");
        ev_soft_reset = 1; cycle("R3");
        cycle("R12");
        ev_watchdog = 1; core_mode = 0; cycle("R6");
        ev_pin_reset = 1; cycle("R5");
        ev_pin_reset = 1; core_mode = 2; cycle("R5");
        ev_brownout = 1; cycle("R4");
        ev_watchdog = 1; core_mode = 1; cycle("R6");
        ev_brownout = 1; cycle("R4");
        ev_watchdog = 1; core_mode = 2; cycle("R6");
        // R9: interrupt wake variants
        ev_int_wake = 1; core_mode = 2; gie_high = 1; cycle("R9");
        ev_brownout = 1; cycle("R4");
        ev_int_wake = 1; core_mode = 1; gie_high = 0; gie_low = 1; cycle("R9");
        ev_brownout = 1; cycle("R4");
        ev_int_wake = 1; core_mode = 3; gie_low = 0; cycle("R9");
        ev_brownout = 1; cycle("R4");
        ev_int_wake = 1; core_mode = 0; cycle("R9");
        // R7 / R8: stack events with and without restart enable
        stack_rst_en = 0; ev_stack_full = 1; cycle("R7");
        ev_stack_under = 1; cycle("R8");
        stack_rst_en = 1; ev_stack_full = 1; cycle("R7");
        ev_brownout = 1; cycle("R4");
        ev_power_on = 1; cycle("R2");
        ev_stack_under = 1; cycle("R8");
        // collisions
        ev_power_on = 1; ev_brownout = 1; ev_pin_reset = 1; sw_wr_en = 1; sw_wr_data = 8'hFF; cycle("R2");
        ev_brownout = 1; ev_watchdog = 1; cycle("R4");
        ev_pin_reset = 1; ev_watchdog = 1; ev_int_wake = 1; core_mode = 2; cycle("R11");
        ev_watchdog = 1; ev_soft_reset = 1; core_mode = 0; cycle("R11");
        ev_soft_reset = 1; ev_stack_under = 1; cycle("R11");
        ev_stack_under = 1; ev_int_wake = 1; stack_rst_en = 0; core_mode = 1; cycle("R11");
        sw_wr_en = 1; sw_wr_data = 8'h13; ev_soft_reset = 1; cycle("R10");
        sw_wr_en = 1; sw_wr_data = 8'h13; cycle("R10");
        // random overlapping strobes
        for (int k = 0; k < 600; k++) begin
            ev_power_on    = ($urandom % 40) == 0;
            ev_brownout    = ($urandom % 20) == 0;
            ev_soft_reset  = ($urandom % 8) == 0;
            ev_pin_reset   = ($urandom % 8) == 0;
            ev_watchdog    = ($urandom % 8) == 0;
            ev_stack_full  = ($urandom % 8) == 0;
            ev_stack_under = ($urandom % 8) == 0;
            ev_int_wake    = ($urandom % 6) == 0;
            core_mode      = 2'($urandom % 4);
            stack_rst_en   = 1'($urandom % 2);
            gie_high       = 1'($urandom % 2);
            gie_low        = 1'($urandom % 2);
            sw_wr_en       = ($urandom % 3) == 0;
            sw_wr_data     = 8'($urandom % 256);
            cycle("R11");
        end
        rst_n = 0; cycle("R1");
        rst_n = 1; cycle("R1");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule